// File: doc/BRIEF.md
# Toggle-Bit Event Queue

This block is a circular queue of 32-bit event records kept in a small register store. A producer side appends 31-bit event numbers; each record it writes carries a generation bit in its top position, and that bit flips every time the producer's write position wraps. A consumer side looks at the record under its own read position and decides whether it is fresh by comparing the generation bit against a local toggle that also flips each time the read position wraps. No occupancy counter or empty flag is kept for the consumer: a stale record is recognised by its generation bit alone.

The consumer can either peek, which reports the head record and leaves everything as it was, or consume, which reports the head record and advances. When nothing fresh is at the head, the reported word is zero, so the event number zero is reserved and the producer refuses it. When every slot holds a record the consumer has not taken, a further write is dropped and a sticky overflow flag is raised. A queue-enable input models whether a queue is configured at all. While it is low, reads return zero and neither side moves.

Top module: `teq_event_queue`

## Requirements
- R1: After a synchronous active-low reset every slot holds zero, both positions are 0, both toggles are 0 and `overflow` is low, so a read request reports `cons_hit` low and `cons_word` zero. This holds even if records were queued before the reset.
- R2: An accepted event (`prod_accept` high) is stored at the tail, and events are reported at the head in the order they were accepted.
- R3: The head record counts as fresh only when its bit 31 differs from the consumer toggle. When `cons_req` is high and the head is fresh, `cons_hit` is high. Otherwise `cons_hit` is low and `cons_word` is zero.
- R4: On a hit, `cons_word` bits 30:0 carry the event number and bit 31 is always 0.
- R5: A consume (`cons_req` and `cons_consume` both high on a hit) advances the read position by one, modulo the power-of-two depth. The consumer toggle inverts when the position wraps to 0, so delivery stays correct over many laps. The producer writes bit 31 as the inverse of its own generation, which starts at 0 and inverts on each wrap.
- R6: A peek (`cons_req` high, `cons_consume` low) reports the head without changing the read position or toggle, so the next read reports the same event.
- R7: A write with event number 0 is refused: `prod_reject` is high in that cycle, `prod_accept` is low and nothing is stored.
- R8: When all slots hold untaken records, a non-zero write is dropped (`prod_accept` low) and `overflow` is set. `overflow` stays high until reset. Fullness is judged on the state at the start of the cycle, so a consume in the same cycle does not make room.
- R9: While `q_enable` is low, `cons_word` is zero, `cons_hit`, `prod_accept` and `prod_reject` are low, and neither writes nor consumes change the queue.
- R10: A consume request on a queue with no fresh record has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_enable | input | 1 | Queue configured; when low, all traffic is ignored |
| prod_valid | input | 1 | Producer write request |
| prod_evt | input | 31 | Event number to append |
| prod_accept | output | 1 | Write taken this cycle |
| prod_reject | output | 1 | Write refused because the event number is zero |
| overflow | output | 1 | Sticky: a write was dropped because the queue was full |
| cons_req | input | 1 | Consumer read request |
| cons_consume | input | 1 | 1 = consume (advance), 0 = peek |
| cons_word | output | 32 | Head event with bit 31 cleared, or zero when nothing is fresh |
| cons_hit | output | 1 | Head record is fresh and a read is requested |

## Verification
The bench builds the block with a depth of four slots (depth log2 of 2). With that depth, filling the queue takes four writes, so overflow is reached quickly. A few hundred mixed cycles also carry both positions around many laps, which exercises every toggle inversion on the producer and the consumer side, including fresh and stale records with both polarities of bit 31. Writes in the same cycle as a consume, at full and at empty, are reached often at this size.

// File: rtl/teq_pkg.sv
// Package: shared widths and the stored record layout of the toggle-bit queue.
package teq_pkg;
    localparam int ENTRY_W = 32;
    localparam int EVT_W   = ENTRY_W - 1;

    // One stored record: generation bit on top, event number below.
    typedef struct packed {
        logic             gen;
        logic [EVT_W-1:0] evt;
    } teq_entry_t;
endpackage

// File: rtl/teq_producer.sv
// Producer side: owns the write position and generation bit, and decides
// accept, reject (zero event) and overflow (all slots untaken).
// Assumes the consumer position/toggle inputs are the registered state.
module teq_producer
    import teq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  valid,
    input  logic [EVT_W-1:0]      evt_in,
    input  logic [DEPTH_LOG2-1:0] rd_idx,
    input  logic                  cons_tog,
    output logic                  wr_en,
    output logic [DEPTH_LOG2-1:0] wr_idx,
    output teq_entry_t            wr_entry,
    output logic                  accept,
    output logic                  reject,
    output logic                  overflow
);
    localparam int IDX_W = DEPTH_LOG2;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;
    logic             gen_q;
    logic             ovf_q;
    logic             full;
    logic             nonzero;

    // Full when one lap ahead of the consumer at the same slot.
    always_comb begin
        full    = (idx_q == rd_idx) && (gen_q != cons_tog);
        nonzero = |evt_in;
        accept  = enable && valid && nonzero && !full;
        reject  = enable && valid && !nonzero;
        idx_nxt = idx_q + IDX_W'(1);
    end

    // Record written: inverse generation on top, event number below.
    always_comb begin
        wr_en        = accept;
        wr_idx       = idx_q;
        wr_entry.gen = ~gen_q;
        wr_entry.evt = evt_in;
    end

    // Advance the write position and flip generation on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            gen_q <= 1'b0;
        end else if (accept) begin
            idx_q <= idx_nxt;
            if (idx_nxt == '0) begin
                gen_q <= ~gen_q;
            end
        end
    end

    // Sticky overflow on a dropped non-zero write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (enable && valid && nonzero && full) begin
            ovf_q <= 1'b1;
        end
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/teq_store.sv
// Record store: DEPTH registered slots cleared by reset, one write port,
// one combinational read port. Assumes at most one write per cycle.
module teq_store
    import teq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] wr_idx,
    input  teq_entry_t            wr_entry,
    input  logic [DEPTH_LOG2-1:0] rd_idx,
    output teq_entry_t            rd_entry
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int IDX_W = DEPTH_LOG2;

    teq_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot clears on reset and loads when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                slots[i] <= wr_entry;
            end
        end
    end

    // Head read.
    assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/teq_consumer.sv
// Consumer side: owns the read position and toggle; judges freshness by
// comparing the head generation bit with the toggle, peeks or consumes.
module teq_consumer
    import teq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  req,
    input  logic                  consume,
    input  teq_entry_t            head,
    output logic [DEPTH_LOG2-1:0] rd_idx,
    output logic                  cons_tog,
    output logic [ENTRY_W-1:0]    word,
    output logic                  hit
);
    localparam int IDX_W = DEPTH_LOG2;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nxt;
    logic             tog_q;
    logic             fresh;

    // Freshness test and output word with the generation bit removed.
    always_comb begin
        fresh   = head.gen != tog_q;
        hit     = enable && req && fresh;
        word    = hit ? {1'b0, head.evt} : '0;
        idx_nxt = idx_q + IDX_W'(1);
    end

    // Advance on consume, invert toggle on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            tog_q <= 1'b0;
        end else if (hit && consume) begin
            idx_q <= idx_nxt;
            if (idx_nxt == '0) begin
                tog_q <= ~tog_q;
            end
        end
    end

    assign rd_idx   = idx_q;
    assign cons_tog = tog_q;
endmodule

// File: rtl/teq_event_queue.sv
// Top: toggle-bit event queue. Producer appends, store holds records,
// consumer peeks or consumes by generation comparison. Depth = 2**DEPTH_LOG2.
module teq_event_queue
    import teq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_enable,
    input  logic               prod_valid,
    input  logic [EVT_W-1:0]   prod_evt,
    output logic               prod_accept,
    output logic               prod_reject,
    output logic               overflow,
    input  logic               cons_req,
    input  logic               cons_consume,
    output logic [ENTRY_W-1:0] cons_word,
    output logic               cons_hit
);
    logic [DEPTH_LOG2-1:0] wr_idx;
    logic [DEPTH_LOG2-1:0] rd_idx;
    logic                  wr_en;
    logic                  cons_tog;
    teq_entry_t            wr_entry;
    teq_entry_t            head;

    teq_producer #(.DEPTH_LOG2(DEPTH_LOG2)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (q_enable),
        .valid    (prod_valid),
        .evt_in   (prod_evt),
        .rd_idx   (rd_idx),
        .cons_tog (cons_tog),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .accept   (prod_accept),
        .reject   (prod_reject),
        .overflow (overflow)
    );

    teq_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (rd_idx),
        .rd_entry (head)
    );

    teq_consumer #(.DEPTH_LOG2(DEPTH_LOG2)) u_cons (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (q_enable),
        .req      (cons_req),
        .consume  (cons_consume),
        .head     (head),
        .rd_idx   (rd_idx),
        .cons_tog (cons_tog),
        .word     (cons_word),
        .hit      (cons_hit)
    );
endmodule

// File: rtl/teq_event_queue_chk.sv
// Checker for the toggle-bit event queue, attached by bind to the top.
module teq_event_queue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        q_enable,
    input logic        prod_valid,
    input logic [30:0] prod_evt,
    input logic        prod_accept,
    input logic        prod_reject,
    input logic        overflow,
    input logic        cons_req,
    input logic        cons_consume,
    input logic [31:0] cons_word,
    input logic        cons_hit
);
    // R3: a miss reports a zero word.
    assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_hit |-> cons_word == 32'd0);

    // R4: bit 31 of the reported word is never set.
    assert_msb_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cons_word[31] == 1'b0);

    // R6: a peek leaves the head unchanged for the next read.
    assert_peek_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_hit && !cons_consume) |=>
            (!cons_req || !q_enable || (cons_hit && cons_word == $past(cons_word))));

    // R7: a zero event is never accepted, and refusals only for zero.
    assert_zero_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prod_reject |-> (!prod_accept && prod_evt == 31'd0 && prod_valid));

    // R8: overflow is sticky and rises only after a write attempt.
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(prod_valid && q_enable && !prod_accept));

    // R9: a disabled queue is silent.
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !q_enable |-> (!cons_hit && !prod_accept && !prod_reject));
endmodule

bind teq_event_queue teq_event_queue_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_enable     (q_enable),
    .prod_valid   (prod_valid),
    .prod_evt     (prod_evt),
    .prod_accept  (prod_accept),
    .prod_reject  (prod_reject),
    .overflow     (overflow),
    .cons_req     (cons_req),
    .cons_consume (cons_consume),
    .cons_word    (cons_word),
    .cons_hit     (cons_hit)
);

// File: tb/teq_event_queue_tb_top.sv
// Bench: behavioural queue model compared with the design every cycle.
module teq_event_queue_tb_top;
    localparam int DL    = 2;
    localparam int DEPTH = 1 << DL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_enable = 1'b0;
    logic        prod_valid = 1'b0;
    logic [30:0] prod_evt = '0;
    logic        prod_accept;
    logic        prod_reject;
    logic        overflow;
    logic        cons_req = 1'b0;
    logic        cons_consume = 1'b0;
    logic [31:0] cons_word;
    logic        cons_hit;

    int unsigned model_q[$];
    bit          model_ovf;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    teq_event_queue #(.DEPTH_LOG2(DL)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_enable     (q_enable),
        .prod_valid   (prod_valid),
        .prod_evt     (prod_evt),
        .prod_accept  (prod_accept),
        .prod_reject  (prod_reject),
        .overflow     (overflow),
        .cons_req     (cons_req),
        .cons_consume (cons_consume),
        .cons_word    (cons_word),
        .cons_hit     (cons_hit)
    );

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare mid-cycle, update model at posedge.
    task automatic step(input bit en, input bit pv, input logic [30:0] ev,
                        input bit rq, input bit cs, input string tag);
        bit exp_hit, exp_acc, exp_rej, full;
        int unsigned exp_word;
        q_enable = en; prod_valid = pv; prod_evt = ev;
        cons_req = rq; cons_consume = cs;
        #2;
        full     = model_q.size() == DEPTH;
        exp_hit  = en && rq && model_q.size() > 0;
        exp_word = exp_hit ? model_q[0] : 0;
        exp_acc  = en && pv && ev != 0 && !full;
        exp_rej  = en && pv && ev == 0;
        cmp(tag, "cons_hit", cons_hit, exp_hit);
        cmp(tag, "cons_word", cons_word, exp_word);
        cmp(tag, "prod_accept", prod_accept, exp_acc);
        cmp(tag, "prod_reject", prod_reject, exp_rej);
        cmp(tag, "overflow", overflow, model_ovf);
        @(posedge clk);
        if (exp_hit && cs) void'(model_q.pop_front());
        if (exp_acc) model_q.push_back(int'(ev));
        if (en && pv && ev != 0 && full) model_ovf = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        q_enable = 1'b1; prod_valid = 1'b0; cons_req = 1'b0; cons_consume = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_q.delete();
        model_ovf = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state.
        step(1, 0, 0, 1, 0, "R1");
        // R2: three events in order, R6: repeated peeks.
        step(1, 1, 31'd5, 0, 0, "R2");
        step(1, 1, 31'd6, 0, 0, "R2");
        step(1, 1, 31'h7fff_ffff, 1, 0, "R2");
        step(1, 0, 0, 1, 0, "R6");
        step(1, 0, 0, 1, 0, "R6");
        step(1, 0, 0, 1, 1, "R2");
        step(1, 0, 0, 1, 1, "R4");
        step(1, 0, 0, 1, 1, "R4");
        // R10: consume on empty.
        step(1, 0, 0, 1, 1, "R10");
        step(1, 0, 0, 1, 0, "R10");
        // R7: zero event refused.
        step(1, 1, 0, 1, 0, "R7");
        step(1, 0, 0, 1, 0, "R7");
        // R8: fill, overflow, stickiness, write-with-consume at full.
        for (int i = 1; i <= DEPTH; i++) step(1, 1, 31'(i + 16), 0, 0, "R8");
        step(1, 1, 31'd99, 0, 0, "R8");
        step(1, 1, 31'd98, 1, 1, "R8");
        step(1, 0, 0, 1, 0, "R8");
        // R5: drain across the wrap.
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, 1, "R5");
        step(1, 0, 0, 1, 0, "R5");
        // R9: disabled queue ignores everything.
        step(1, 1, 31'd40, 0, 0, "R9");
        step(0, 1, 31'd41, 1, 1, "R9");
        step(0, 1, 0, 1, 1, "R9");
        step(1, 0, 0, 1, 0, "R9");
        // R5: mixed traffic over many laps.
        for (int i = 0; i < 600; i++) begin
            bit en, pv, rq, cs;
            logic [30:0] ev;
            en = ($urandom % 10) != 0;
            pv = ($urandom % 3) != 0;
            ev = (($urandom % 12) == 0) ? 31'd0 : 31'($urandom);
            rq = ($urandom % 4) != 0;
            cs = ($urandom % 2) != 0;
            step(en, pv, ev, rq, cs, "R5");
        end
        // R1: reset with records queued clears everything.
        step(1, 1, 31'd3, 0, 0, "R1");
        do_reset();
        step(1, 0, 0, 1, 1, "R1");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule